// File: doc/BRIEF.md
# Dual-Width Access Byte FIFO Pair

This block sits between a register bus and a serial shift engine. It holds one byte queue for outgoing data and one for incoming data. Software or a DMA engine fills the outgoing queue and empties the incoming queue through a register port. Each queue has two data addresses: one moves a full 32-bit word (four bytes) per access, and the other moves a single byte. The serial engine sees two plain byte streams with valid/ready handshakes: one it drains and one it fills.

Both queues report their fill level as status flags, and these flags are computed from the current level on every cycle. Two sticky events sit beside the level flags. One is a completion event, raised when the outgoing queue has drained after being written. The other is an illegal-access event. A one-hot controller tracks completion through three states:

- IDLE: nothing pending.
- BUSY: entered from IDLE or DONE on any accepted outgoing write.
- DONE: entered from BUSY when the last queued outgoing byte is taken while nothing new is written. It leaves for IDLE on a clear of the completion bit, or for BUSY on a new accepted write.

A synchronous soft reset forces IDLE.

Top module: `dw_access_fifo`

## Requirements
- R1: After rst_n or a one-cycle soft_rst, both queues are empty, status reads 13'h003 (only outgoing empty and outgoing trigger set), tx_valid is 0 and rx_ready is 1.
- R2: A write to address 0x20 enqueues the four bytes of reg_wdata, bits 7:0 first and bits 31:24 last, and they leave on tx_data in that order.
- R3: A write to address 0x24 enqueues reg_wdata[7:0] as one byte.
- R4: A read of address 0x28 dequeues four bytes and returns them on reg_rdata at the next clock edge, the oldest byte in bits 7:0 and the newest in bits 31:24.
- R5: A read of address 0x2C dequeues one byte and returns it in reg_rdata[7:0] with bits 31:8 zero, at the next clock edge.
- R6: The following accesses are dropped and leave the queue level unchanged: a word write with fewer than four bytes free, a byte write to a full queue, a word read with fewer than four bytes held, and a byte read of an empty queue. Each one raises bad_access for one cycle at the next edge and sets sticky status bit 12.
- R7: Outgoing flags, from level L with depth D: bit 3 is set when L > D-4 (no room for a word), bit 2 when L >= D/2, bit 1 when L == 0, and bit 0 when L <= TX_TRIG.
- R8: Incoming flags, from level L: bit 8 is set when L == D, bit 7 when L >= D/2, bit 6 when L >= 4, bit 5 when L >= RX_TRIG, and bit 11 when L >= 1.
- R9: rx_ready is 0 while the incoming queue is full, and a byte is taken only on a cycle with rx_valid and rx_ready both high.
- R10: Status bit 9 (completion) rises at the edge that removes the last outgoing byte, provided at least one outgoing write was accepted since the last reset or clear. An accepted outgoing write clears it.
- R11: A write to address 0x38 clears sticky bit 9 where reg_wdata[9] is 1 and sticky bit 12 where reg_wdata[12] is 1. Level flags are unaffected and show the current level in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of both queues and all sticky state |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Engine takes the outgoing byte |
| tx_data | output | 8 | Oldest outgoing byte |
| rx_valid | input | 1 | Engine offers an incoming byte |
| rx_ready | output | 1 | Incoming queue has room |
| rx_data | input | 8 | Incoming byte |
| status | output | 13 | Level flags and sticky events |
| bad_access | output | 1 | One-cycle pulse on a dropped access |

## Verification
The bench builds the block with DEPTH=16, TX_TRIG=4 and RX_TRIG=8. At this depth, a sweep can walk every level from empty to full in both directions and compare all nine level flags against thresholds computed in the bench. The small depth also brings the word-room boundary at 13 bytes, and the illegal accesses at both ends, within a few dozen cycles. Byte ordering is checked through full word round trips in both directions.

// File: rtl/dw_fifo_pkg.sv
package dw_fifo_pkg;
    localparam logic [7:0] ADDR_TX_WORD = 8'h20;
    localparam logic [7:0] ADDR_TX_BYTE = 8'h24;
    localparam logic [7:0] ADDR_RX_WORD = 8'h28;
    localparam logic [7:0] ADDR_RX_BYTE = 8'h2C;
    localparam logic [7:0] ADDR_CLEAR   = 8'h38;

    localparam int ST_W      = 13;
    localparam int BIT_DONE  = 9;
    localparam int BIT_ILLEG = 12;

    typedef enum logic [2:0] {
        S_IDLE = 3'b001,
        S_BUSY = 3'b010,
        S_DONE = 3'b100
    } done_state_t;
endpackage

// File: rtl/dw_byte_queue.sv
module dw_byte_queue #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic [2:0]                   push_n,
    input  logic [31:0]                  push_data,
    input  logic [2:0]                   pop_n,
    output logic [31:0]                  head,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (i < int'(push_n)) begin
                mem[wr_ptr + AW'(i)] <= push_data[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            level  <= level + CW'(push_n) - CW'(pop_n);
        end
    end

    generate
        for (genvar g = 0; g < 4; g++) begin : g_head
            assign head[8*g +: 8] = mem[rd_ptr + AW'(g)];
        end
    endgenerate

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);
endmodule

// File: rtl/dw_done_ctrl.sv
module dw_done_ctrl
    import dw_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic tx_accept,
    input  logic tx_last_out,
    input  logic clear_done,
    input  logic tx_empty,
    output logic done
);
    done_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: if (tx_accept) state_nx = S_BUSY;
                S_BUSY: if (tx_last_out && !tx_accept) state_nx = S_DONE;
                S_DONE: begin
                    if (tx_accept)       state_nx = S_BUSY;
                    else if (clear_done) state_nx = S_IDLE;
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_comb begin
        done = (state == S_DONE);
    end

    assert_done_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tx_empty);
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state) && state != 3'b000);
endmodule

// File: rtl/dw_access_fifo.sv
module dw_access_fifo
    import dw_fifo_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int TX_TRIG = 16,
    parameter int RX_TRIG = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [7:0]   reg_addr,
    input  logic [31:0]  reg_wdata,
    output logic [31:0]  reg_rdata,
    output logic         tx_valid,
    input  logic         tx_ready,
    output logic [7:0]   tx_data,
    input  logic         rx_valid,
    output logic         rx_ready,
    input  logic [7:0]   rx_data,
    output logic [12:0]  status,
    output logic         bad_access
);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LVL_ROOM = CW'(DEPTH-4);
    localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH/2);
    localparam logic [CW-1:0] LVL_TXT  = CW'(TX_TRIG);
    localparam logic [CW-1:0] LVL_RXT  = CW'(RX_TRIG);
    localparam logic [CW-1:0] LVL_WORD = CW'(4);

    logic [CW-1:0] tx_lvl, rx_lvl;
    logic [31:0]   tx_head, rx_head;
    logic [2:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic          tx_w_word, tx_w_byte, rx_r_word, rx_r_byte;
    logic          tx_w_word_ok, tx_w_byte_ok, rx_r_word_ok, rx_r_byte_ok;
    logic          illegal, clr_wr, done, illeg_sticky;

    assign tx_w_word = reg_wr && reg_addr == ADDR_TX_WORD;
    assign tx_w_byte = reg_wr && reg_addr == ADDR_TX_BYTE;
    assign rx_r_word = reg_rd && reg_addr == ADDR_RX_WORD;
    assign rx_r_byte = reg_rd && reg_addr == ADDR_RX_BYTE;
    assign clr_wr    = reg_wr && reg_addr == ADDR_CLEAR;

    assign tx_w_word_ok = tx_w_word && tx_lvl <= LVL_ROOM;
    assign tx_w_byte_ok = tx_w_byte && tx_lvl <  LVL_FULL;
    assign rx_r_word_ok = rx_r_word && rx_lvl >= LVL_WORD;
    assign rx_r_byte_ok = rx_r_byte && rx_lvl != '0;

    assign illegal = (tx_w_word && !tx_w_word_ok) || (tx_w_byte && !tx_w_byte_ok) ||
                     (rx_r_word && !rx_r_word_ok) || (rx_r_byte && !rx_r_byte_ok);

    assign tx_push_n = tx_w_word_ok ? 3'd4 : (tx_w_byte_ok ? 3'd1 : 3'd0);
    assign tx_valid  = tx_lvl != '0;
    assign tx_data   = tx_head[7:0];
    assign tx_pop_n  = (tx_valid && tx_ready) ? 3'd1 : 3'd0;

    assign rx_ready  = rx_lvl != LVL_FULL;
    assign rx_push_n = (rx_valid && rx_ready) ? 3'd1 : 3'd0;
    assign rx_pop_n  = rx_r_word_ok ? 3'd4 : (rx_r_byte_ok ? 3'd1 : 3'd0);

    dw_byte_queue #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push_n(tx_push_n), .push_data(tx_w_word ? reg_wdata : {24'd0, reg_wdata[7:0]}),
        .pop_n(tx_pop_n), .head(tx_head), .level(tx_lvl)
    );

    dw_byte_queue #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .push_n(rx_push_n), .push_data({24'd0, rx_data}),
        .pop_n(rx_pop_n), .head(rx_head), .level(rx_lvl)
    );

    dw_done_ctrl u_done (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst),
        .tx_accept(tx_push_n != 3'd0),
        .tx_last_out(tx_pop_n != 3'd0 && tx_lvl == CW'(1)),
        .clear_done(clr_wr && reg_wdata[BIT_DONE]),
        .tx_empty(tx_lvl == '0),
        .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata    <= '0;
            bad_access   <= 1'b0;
            illeg_sticky <= 1'b0;
        end else if (soft_rst) begin
            reg_rdata    <= '0;
            bad_access   <= 1'b0;
            illeg_sticky <= 1'b0;
        end else begin
            bad_access <= illegal;
            if (illegal)
                illeg_sticky <= 1'b1;
            else if (clr_wr && reg_wdata[BIT_ILLEG])
                illeg_sticky <= 1'b0;
            if (reg_rd) begin
                if (rx_r_word_ok)      reg_rdata <= rx_head;
                else if (rx_r_byte_ok) reg_rdata <= {24'd0, rx_head[7:0]};
                else                   reg_rdata <= '0;
            end
        end
    end

    always_comb begin
        status     = '0;
        status[0]  = tx_lvl <= LVL_TXT;
        status[1]  = tx_lvl == '0;
        status[2]  = tx_lvl >= LVL_HALF;
        status[3]  = tx_lvl >  LVL_ROOM;
        status[5]  = rx_lvl >= LVL_RXT;
        status[6]  = rx_lvl >= LVL_WORD;
        status[7]  = rx_lvl >= LVL_HALF;
        status[8]  = rx_lvl == LVL_FULL;
        status[BIT_DONE]  = done;
        status[11] = rx_lvl != '0;
        status[BIT_ILLEG] = illeg_sticky;
    end

    assert_drop_keeps_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_w_word && !tx_w_word_ok && !soft_rst) |=> tx_lvl <= $past(tx_lvl));
    assert_bad_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> status[BIT_ILLEG]);
    assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !soft_rst) |=> rx_lvl <= $past(rx_lvl));
    assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd && !soft_rst) |=> $stable(reg_rdata));
endmodule

// File: tb/tb_dw_access_fifo.sv
module tb_dw_access_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int D = 16;
    localparam int TXT = 4;
    localparam int RXT = 8;
    localparam logic [12:0] LVLMASK = 13'h09EF;

    logic clk = 0, rst_n = 0, soft_rst = 0, reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, bad_access;
    logic [7:0] tx_data, rx_data = 0;
    logic [12:0] status;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dw_access_fifo #(.DEPTH(D), .TX_TRIG(TXT), .RX_TRIG(RXT)) dut (.*);

    function automatic logic [12:0] exp_tx(int l);
        logic [12:0] s = '0;
        s[0] = l <= TXT; s[1] = l == 0; s[2] = l >= D/2; s[3] = l > D-4;
        return s;
    endfunction
    function automatic logic [12:0] exp_rx(int l);
        logic [12:0] s = '0;
        s[5] = l >= RXT; s[6] = l >= 4; s[7] = l >= D/2; s[8] = l == D; s[11] = l >= 1;
        return s;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask
    task automatic rd(logic [7:0] a);
        reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0;
    endtask
    task automatic pull(output logic [7:0] b);
        b = tx_data; tx_ready = 1;
        @(negedge clk); tx_ready = 0;
    endtask
    task automatic push(logic [7:0] b);
        rx_valid = 1; rx_data = b;
        @(negedge clk); rx_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 status", 32'(status), 32'h003);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 1);

        // byte writes sweep, R3 R7
        for (int k = 1; k <= D; k++) begin
            wr(8'h24, 32'hFFFFFF40 + 32'(k));
            chk("R7 tx flags", 32'(status & LVLMASK), 32'(exp_tx(k)));
        end
        wr(8'h24, 32'h99);
        chk("R6 bad_access tx8 full", 32'(bad_access), 1);
        chk("R6 sticky", 32'(status[12]), 1);
        chk("R6 level kept", 32'(status & LVLMASK), 32'(exp_tx(D)));
        for (int k = 1; k <= D; k++) begin
            chk("R3 tx byte order", 32'(tx_data), 32'(8'h40 + k));
            pull(b);
            chk("R7 tx drain flags", 32'(status & LVLMASK), 32'(exp_tx(D - k)));
        end
        chk("R10 done set", 32'(status[9]), 1);
        wr(8'h38, 32'h1200);
        chk("R11 cleared", 32'(status), 32'h003);

        // word writes, R2
        wr(8'h20, 32'h44332211);
        chk("R2 level 4", 32'(status & LVLMASK), 32'(exp_tx(4)));
        chk("R10 busy", 32'(status[9]), 0);
        wr(8'h20, 32'hDDCCBBAA);
        chk("R2 level 8", 32'(status & LVLMASK), 32'(exp_tx(8)));
        for (int k = 0; k < 8; k++) begin
            logic [63:0] ref_q = 64'hDDCCBBAA44332211;
            pull(b);
            chk("R2 word byte order", 32'(b), 32'(ref_q[8*k +: 8]));
        end
        chk("R10 done again", 32'(status[9]), 1);
        wr(8'h20, 32'h0);  // accepted write leaves DONE
        chk("R10 cleared by write", 32'(status[9]), 0);
        for (int k = 0; k < 2; k++) wr(8'h20, 32'h0);
        wr(8'h24, 32'h0);
        chk("R7 room boundary", 32'(status & LVLMASK), 32'(exp_tx(13)));
        wr(8'h20, 32'h12345678);
        chk("R6 tx32 no room", 32'(bad_access), 1);
        for (int k = 0; k < 13; k++) pull(b);
        chk("R6 level 13 kept", 32'(tx_valid), 0);

        // incoming sweep, R8 R9
        wr(8'h38, 32'h1200);
        for (int k = 1; k <= D; k++) begin
            push(8'h80 + 8'(k - 1));
            chk("R8 rx flags", 32'(status & LVLMASK), 32'(exp_rx(k) | exp_tx(0)));
        end
        chk("R9 ready low", 32'(rx_ready), 0);
        push(8'hEE);
        chk("R9 full ignored", 32'(status & LVLMASK), 32'(exp_rx(D) | exp_tx(0)));
        for (int w = 0; w < 4; w++) begin
            rd(8'h28);
            chk("R4 word read", reg_rdata,
                {8'h83 + 8'(4*w), 8'h82 + 8'(4*w), 8'h81 + 8'(4*w), 8'h80 + 8'(4*w)});
            chk("R8 rx drain", 32'(status & LVLMASK), 32'(exp_rx(D - 4*(w+1)) | exp_tx(0)));
        end
        rd(8'h2C);
        chk("R6 rx8 empty", 32'(bad_access), 1);

        // byte reads, R5
        push(8'h5A); push(8'h5B); push(8'h5C);
        rd(8'h28);
        chk("R6 rx32 short", 32'(bad_access), 1);
        chk("R6 rx32 level kept", 32'(status & LVLMASK), 32'(exp_rx(3) | exp_tx(0)));
        for (int k = 0; k < 3; k++) begin
            rd(8'h2C);
            chk("R5 byte read", reg_rdata, 32'(8'h5A + k));
        end
        chk("R5 drained", 32'(status[11]), 0);

        // soft reset, R1
        push(8'h01); wr(8'h20, 32'h1); wr(8'h24, 32'h2);
        soft_rst = 1; @(negedge clk); soft_rst = 0;
        chk("R1 soft reset status", 32'(status), 32'h003);
        chk("R1 soft reset tx", 32'(tx_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule